// File: doc/BRIEF.md
# Redundant-Basis All-One-Polynomial Field Multiplier

This block multiplies two elements of the binary extension field GF(2^M). The field is built on the all-one polynomial 1 + x + x^2 + ... + x^M, which must be irreducible for the chosen M. Every operand and result is carried as M+1 coefficient bits over the powers x^0 through x^M. Bit k of a bus is the coefficient of x^k. The ring of these vectors wraps at x^(M+1) = 1. For that reason the product is a plain cyclic convolution: an array of two-input AND gates forms every partial product, and each output bit is summed by a balanced XOR tree. No separate modular reduction stage follows.

The redundant form gives each field element two encodings. The vector and its bitwise complement mean the same element, because the all-ones vector stands for zero. Two small helpers sit beside the multiplier. The first widens a canonical M-bit element into redundant form. The second folds the redundant product back to a unique canonical M-bit value.

A parameter chooses whether a register stage follows the XOR trees. Without the register the product path is purely combinational. With the register the product has one clock of latency and a synchronous active-high reset.

Top module: `aop_rdm_mul`

## Requirements
- R1: Product bit k (the coefficient of x^k) equals the XOR over i = 0..M of op_a[i] AND op_b[(k - i) mod (M+1)].
- R2: prod_canon equals the canonical reduction of op_a times the canonical reduction of op_b, multiplied as polynomials over GF(2) and reduced modulo the all-one polynomial of degree M.
- R3: The canonical reduction works in two steps. If bit M of the redundant value is 1, all M+1 bits are first complemented; bit M is then dropped. As a result, the all-zeros vector and the all-ones vector both reduce to 0.
- R4: canon_as_red equals canon_in with a 0 appended as bit M, with no clock involved.
- R5: With OUT_REG = 0, prod follows op_a and op_b within the same cycle, without waiting for a clock edge.
- R6: With OUT_REG = 1, prod shows the product of the operands sampled at the previous rising clock edge. While rst is high at a rising edge, prod is cleared to 0.
- R7: The XOR of all bits of prod equals (XOR of all bits of op_a) AND (XOR of all bits of op_b).
- R8: When op_b is the redundant unit (only bit 0 set), prod equals op_a. When either operand is an encoding of zero, prod_canon is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | M+1 | First operand, redundant form |
| op_b | input | M+1 | Second operand, redundant form |
| canon_in | input | M | Canonical element to be widened |
| canon_as_red | output | M+1 | canon_in in redundant form |
| prod | output | M+1 | Product, redundant form |
| prod_canon | output | M | Product reduced to canonical form |

## Verification
The bench builds two copies of the block. The first uses M = 4 with the output register. At that size all 1024 operand pairs can be swept, which covers both encodings of zero, the unit, the register latency and the reset value. The second uses M = 10 without the register. It takes random operands plus forced all-ones and all-zeros operands, which exercises the wider XOR trees and the same-cycle combinational path. Every result is compared against a shift-and-add product reduced modulo the all-one polynomial in the bench.

// File: rtl/aop_pkg.sv
package aop_pkg;

    // Returns 1 when 1 + x + ... + x^m is irreducible over GF(2):
    // m+1 must be prime and 2 must have multiplicative order m modulo m+1.
    function automatic bit aop_ok(input int m);
        int p;
        int v;
        p = m + 1;
        if (m < 2) return 1'b0;
        for (int d = 2; d < p; d++) begin
            if (p % d == 0) return 1'b0;
        end
        v = 1;
        for (int k = 1; k <= m; k++) begin
            v = (v * 2) % p;
            if (v == 1 && k < m) return 1'b0;
        end
        return (v == 1);
    endfunction

endpackage

// File: rtl/rdm_xor_tree.sv
module rdm_xor_tree #(
    parameter int N = 5
) (
    input  logic [N-1:0] bits_i,
    output logic         sum_o
);
    localparam int LEVELS = (N > 1) ? $clog2(N) : 0;
    localparam int W      = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int WL = W >> l;
        logic [WL-1:0] v;
        if (l == 0) begin : g_leaf
            assign v = WL'(bits_i);
        end else begin : g_pair
            for (genvar j = 0; j < WL; j++) begin : g_node
                assign v[j] = g_lvl[l-1].v[2*j] ^ g_lvl[l-1].v[2*j+1];
            end
        end
    end

    assign sum_o = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/rdm_mul_core.sv
module rdm_mul_core #(
    parameter int M = 4
) (
    input  logic [M:0] a_i,
    input  logic [M:0] b_i,
    output logic [M:0] p_o
);
    localparam int N = M + 1;

    logic [N-1:0] pp [N];

    // R1: coefficient k gathers a[i]*b[(k-i) mod N]
    for (genvar k = 0; k < N; k++) begin : g_col
        for (genvar i = 0; i < N; i++) begin : g_and
            assign pp[k][i] = a_i[i] & b_i[(k - i + N) % N];
        end
        rdm_xor_tree #(.N(N)) u_tree (
            .bits_i (pp[k]),
            .sum_o  (p_o[k])
        );
    end

endmodule

// File: rtl/rdm_embed.sv
module rdm_embed #(
    parameter int M = 4
) (
    input  logic [M-1:0] canon_i,
    output logic [M:0]   red_o
);
    assign red_o = {1'b0, canon_i};
endmodule

// File: rtl/rdm_reduce.sv
module rdm_reduce #(
    parameter int M = 4
) (
    input  logic [M:0]   red_i,
    output logic [M-1:0] canon_o
);
    logic [M:0] folded;

    assign folded  = red_i[M] ? ~red_i : red_i;
    assign canon_o = folded[M-1:0];

    always_comb begin
        if (&red_i) begin
            a_r3_ones_is_zero: assert (canon_o == '0);
        end
        if (!red_i[M]) begin
            a_r3_low_kept: assert (canon_o == red_i[M-1:0]);
        end
    end
endmodule

// File: rtl/aop_rdm_mul.sv
module aop_rdm_mul #(
    parameter int M       = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [M:0]   op_a,
    input  logic [M:0]   op_b,
    input  logic [M-1:0] canon_in,
    output logic [M:0]   canon_as_red,
    output logic [M:0]   prod,
    output logic [M-1:0] prod_canon
);
    localparam logic [M:0] UNIT = (M+1)'(1);

    if (!aop_pkg::aop_ok(M)) begin : g_bad_m
        $error("aop_rdm_mul: all-one polynomial is reducible for this M");
    end

    logic [M:0] conv;

    rdm_mul_core #(.M(M)) u_core (
        .a_i (op_a),
        .b_i (op_b),
        .p_o (conv)
    );

    rdm_embed #(.M(M)) u_embed (
        .canon_i (canon_in),
        .red_o   (canon_as_red)
    );

    rdm_reduce #(.M(M)) u_reduce (
        .red_i   (prod),
        .canon_o (prod_canon)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) prod <= '0;
            else     prod <= conv;
        end

        a_r6_reset_clears: assert property (@(posedge clk)
            rst |=> prod == '0);
        a_r7_parity: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (^prod) == $past((^op_a) & (^op_b)));
        a_r8_unit: assert property (@(posedge clk) disable iff (rst)
            op_b == UNIT |=> prod == $past(op_a));
    end else begin : g_comb
        assign prod = conv;

        a_r7_parity: assert property (@(posedge clk) disable iff (rst)
            (^prod) == ((^op_a) & (^op_b)));
        a_r8_unit: assert property (@(posedge clk) disable iff (rst)
            op_b == UNIT |-> prod == op_a);
    end

endmodule

// File: tb/aop_rdm_mul_tb.sv
module aop_rdm_mul_tb;
    localparam int NM = 4;
    localparam int WM = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4ns clk = ~clk;

    logic [NM:0]   n_a, n_b, n_red, n_prod;
    logic [NM-1:0] n_cin, n_pc;
    logic [WM:0]   w_a, w_b, w_red, w_prod;
    logic [WM-1:0] w_cin, w_pc;

    aop_rdm_mul #(.M(NM), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst(rst), .op_a(n_a), .op_b(n_b), .canon_in(n_cin),
        .canon_as_red(n_red), .prod(n_prod), .prod_canon(n_pc));

    aop_rdm_mul #(.M(WM), .OUT_REG(1'b0)) u_dut_wide (
        .clk(clk), .rst(rst), .op_a(w_a), .op_b(w_b), .canon_in(w_cin),
        .canon_as_red(w_red), .prod(w_prod), .prod_canon(w_pc));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [31:0] ref_reduce(input logic [31:0] r, input int m);
        logic [31:0] v;
        v = r[m] ? ~r : r;
        return v & ((32'd1 << m) - 1);
    endfunction

    function automatic logic [31:0] ref_mulmod(input logic [31:0] a, input logic [31:0] b, input int m);
        logic [63:0] acc;
        logic [63:0] aop;
        acc = '0;
        for (int i = 0; i < m; i++) if (b[i]) acc ^= 64'(a) << i;
        aop = (64'd1 << (m + 1)) - 1;
        for (int d = 2 * m; d >= m; d--) if (acc[d]) acc ^= aop << (d - m);
        return acc[31:0];
    endfunction

    function automatic logic [31:0] ref_conv(input logic [31:0] a, input logic [31:0] b, input int m);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i <= m; i++)
            for (int j = 0; j <= m; j++)
                if (a[i] && b[j]) r[(i + j) % (m + 1)] ^= 1'b1;
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev_conv;
        bit          prev_ok;
        logic [31:0] wa, wb, ca, cb;
        n_a = 5'b10101; n_b = 5'b00111; n_cin = '0;
        w_a = '0; w_b = '0; w_cin = '0;
        repeat (2) @(negedge clk);
        check("R6 reset value", 32'(n_prod), 32'd0);
        rst = 1'b0;
        prev_ok = 1'b0;
        prev_conv = '0;

        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                @(negedge clk);
                n_a = 5'(a); n_b = 5'(b); n_cin = 4'(a ^ b);
                wa = 32'($urandom) & 32'h7FF;
                wb = 32'($urandom) & 32'h7FF;
                if (b == 0)  wa = 32'h7FF;
                if (b == 1)  wb = 32'h000;
                if (b == 2)  wb = 32'h001;
                w_a = 11'(wa); w_b = 11'(wb); w_cin = 10'(wa);
                #1ns;
                if (prev_ok) check("R6 holds until edge", 32'(n_prod), prev_conv);
                check("R5 R1 wide same-cycle product", 32'(w_prod), ref_conv(wa, wb, WM));
                ca = ref_reduce(wa, WM); cb = ref_reduce(wb, WM);
                check("R2 wide canonical product", 32'(w_pc), ref_mulmod(ca, cb, WM));
                check("R4 wide embed", 32'(w_red), wa & 32'h3FF);
                if (wa == 32'h7FF || wb == 32'h0)
                    check("R8 wide zero operand", 32'(w_pc), 32'd0);
                @(posedge clk);
                #2ns;
                check("R1 narrow convolution", 32'(n_prod), ref_conv(32'(a), 32'(b), NM));
                ca = ref_reduce(32'(a), NM); cb = ref_reduce(32'(b), NM);
                check("R2 narrow canonical product", 32'(n_pc), ref_mulmod(ca, cb, NM));
                check("R3 narrow reduction of prod", 32'(n_pc), ref_reduce(32'(n_prod), NM));
                check("R4 narrow embed", 32'(n_red), 32'((a ^ b) & 15));
                check("R7 parity", 32'(^n_prod), 32'((^a[4:0]) & (^b[4:0])));
                if (b == 1) check("R8 unit operand", 32'(n_prod), 32'(a));
                if (a == 0 || a == 31) check("R8 zero encodings", 32'(n_pc), 32'd0);
                prev_conv = ref_conv(32'(a), 32'(b), NM);
                prev_ok = 1'b1;
            end
        end

        @(negedge clk);
        rst = 1'b1;
        n_a = 5'b11001; n_b = 5'b00110;
        @(posedge clk);
        #2ns;
        check("R6 synchronous reset clears", 32'(n_prod), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule